// File: doc/BRIEF.md
# Streaming Frame Classifier Engine

This block sorts received Ethernet frames into up to eight categories while the frame is still arriving. Frame data enters as a stream of 16-bit words, one word per valid cycle. For each word, one very long instruction word runs from a small program memory. The instruction operates on a bank of thirty-two one-bit flag registers. An instruction can do one of three things: compare a masked frame word against a constant, test a single bit of a frame word, or combine flags with two- or three-operand boolean logic.

The program counter is driven only by the arrival of frame words. Nothing throttles the stream, so an instruction can only see words that have already arrived. The result is produced when the frame ends, or earlier if a finish instruction runs first. The result is an eight-bit class vector plus a drop flag, and it is announced with a one-cycle valid pulse.

Software loads the program through two 32-bit control registers. The same registers turn the filter on and off.

Top module: `pkt_classifier`

## Requirements
- R1: Flag register 0 always reads as 0; any instruction that targets it leaves it at 0.
- R2: Flags 24 to 31 give class bits 0 to 7 and flag 23 gives the drop bit. `result_valid` is high for exactly one cycle, in the cycle after the clock edge that accepted the triggering word.
- R3: Each accepted word advances the program counter by one. A word with `rx_sof` high runs address 0. The instruction at address N reads the stored word at its offset, and the offset may be any value from 0 to N, including the word arriving in that cycle.
- R4: Compare (bit 35=0, bit 34=0, bit 33=0) uses these fields:
  - op in [2:0];
  - destination in [6:3], so only flags 0 to 15 can be targets;
  - word offset in [12:7];
  - value in [28:13];
  - nibble enables in [32:29], where bit 29+n keeps nibble n of the mask.

  The instruction computes dest = dest OP ((word & mask) == value).
- R5: Bit test (bit 34=0, bit 33=1) sets dest = dest OP word[offset][n]. The bit number n is in [16:13]. The op, destination and offset fields are the same as for compare.
- R6: Logic (bit 34=1) uses these fields:
  - op in [2:0];
  - destination bits 3:0 in [6:3] and destination bit 4 in bit 7;
  - A in [12:8], B in [17:13] and C in [22:18];
  - op2 in [25:23].

  The instruction computes dest = (A op B) op2 C. When op2 is 3, the instruction computes dest = A op B. An all-zero logic word does nothing.
- R7: The op codes are 0=AND, 1=OR, 2=XOR, 4=MOV and 5=NOT. MOV yields the new bit (in logic, the A operand) and NOT yields its inverse. Code 3 keeps the accumulating operand.
- R8: A word with bit 35 set ends the program. The result is issued from that word, and the end of the same frame raises no second pulse.
- R9: If no finish word runs, the result is issued on the word with `rx_eof` high, and it includes that word's instruction.
- R10: After each result all flags are cleared, so the next frame starts from zero.
- R11: Beyond 64 words, execution stops after address 63, and the frame's result still comes at its end.
- R12: While the filter is disabled, every frame ends with class 0, drop 0 and a valid pulse. The loaded program is kept.
- R13: A write to control register 1 (`cfg_sel`=1) stores the low 12 instruction bits from data [11:0]. A write to control register 0 does the following:
  - it sets the enable from bit 0;
  - when bit 1 is set, it writes {data[31:8], stored low bits} to the address in data [7:2].
- R14: After reset `result_valid`, `result_class` and `result_drop` are 0 and the filter is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_sel | input | 1 | 0 selects control register 0, 1 selects control register 1 |
| cfg_wdata | input | 32 | Control write data |
| rx_valid | input | 1 | A frame word is present this cycle |
| rx_sof | input | 1 | Word is the first of a frame |
| rx_eof | input | 1 | Word is the last of a frame |
| rx_data | input | 16 | Frame word |
| result_valid | output | 1 | One-cycle pulse when a classification is issued |
| result_class | output | 8 | Class vector |
| result_drop | output | 1 | Drop flag |

## Verification
One test program is loaded and then driven with several frames. The frames differ in the destination-address words, a word whose high byte must be ignored by a half-nibble mask, the polarity of two tested bits, and an accumulating AND word. Each frame therefore separates a different group of compare, bit-test and logic results. Truncated frames show that results follow word pacing: a seven-word frame omits later instructions, and a one-word frame after a drop-tagged frame shows that flags are cleared. A 70-word frame and a 63-word frame, run on a program whose address 0 undoes address 63, separate execution that stops at the last address from execution that wraps or falls short. A disabled run followed by a re-enabled run separates forced zero results from a lost program.

// File: rtl/pcls_pkg.sv
package pcls_pkg;
    localparam int WORD_W     = 16;
    localparam int INSTR_W    = 36;
    localparam int NFLAGS     = 32;
    localparam int DROP_FLAG  = 23;
    localparam int CLASS_BASE = 24;
    localparam int CLASS_W    = 8;
    localparam int OFF_W      = 6;

    // boolean operator codes shared by all instruction kinds
    localparam logic [2:0] OP_AND  = 3'd0;
    localparam logic [2:0] OP_OR   = 3'd1;
    localparam logic [2:0] OP_XOR  = 3'd2;
    localparam logic [2:0] OP_KEEP = 3'd3;
    localparam logic [2:0] OP_MOV  = 3'd4;
    localparam logic [2:0] OP_NOT  = 3'd5;

    // acc is the operand that survives an unused code, src is the new bit
    function automatic logic combine(input logic [2:0] op, input logic acc, input logic src);
        logic r;
        case (op)
            OP_AND:  r = acc & src;
            OP_OR:   r = acc | src;
            OP_XOR:  r = acc ^ src;
            OP_MOV:  r = src;
            OP_NOT:  r = ~src;
            default: r = acc;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pcls_cfg.sv
module pcls_cfg
    import pcls_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic               cfg_sel,
    input  logic [31:0]        cfg_wdata,
    input  logic [AW-1:0]      rd_addr,
    output logic [INSTR_W-1:0] instr,
    output logic               enable
);
    localparam int LO_W = 12;

    typedef struct packed {
        logic [LO_W-1:0] lo;
        logic            en;
    } cfg_t;

    cfg_t st_d, st_q;
    logic [INSTR_W-1:0] mem [DEPTH];
    logic               mem_we;

    always_comb begin
        st_d   = st_q;
        mem_we = 1'b0;
        if (cfg_wr_en) begin
            if (cfg_sel) begin
                st_d.lo = cfg_wdata[LO_W-1:0];
            end else begin
                st_d.en = cfg_wdata[0];
                mem_we  = cfg_wdata[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[cfg_wdata[2 +: AW]] <= {cfg_wdata[31:8], st_q.lo};
    end

    assign instr  = mem[rd_addr];
    assign enable = st_q.en;
endmodule

// File: rtl/pcls_wordbuf.sv
module pcls_wordbuf
    import pcls_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] words [DEPTH];
    logic [AW-1:0]     off;

    assign off = rd_off[AW-1:0];

    always_ff @(posedge clk) begin
        if (wr_en) words[wr_idx] <= wr_data;
    end

    // the word arriving this cycle is visible to its own instruction
    assign rd_word = (wr_en && off == wr_idx) ? wr_data : words[off];
endmodule

// File: rtl/pcls_exec.sv
module pcls_exec
    import pcls_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic [WORD_W-1:0]  word,
    input  logic [NFLAGS-1:0]  flags_in,
    output logic [OFF_W-1:0]   word_off,
    output logic               is_fin,
    output logic [NFLAGS-1:0]  flags_out
);
    logic [2:0]        op, op2;
    logic [4:0]        dst, ra, rb, rc;
    logic [WORD_W-1:0] mask;
    logic              probe, stage1, result;

    assign is_fin   = instr[35];
    assign word_off = instr[12:7];
    assign op       = instr[2:0];
    assign op2      = instr[25:23];
    assign ra       = instr[12:8];
    assign rb       = instr[17:13];
    assign rc       = instr[22:18];

    always_comb begin
        for (int n = 0; n < WORD_W / 4; n++) mask[4*n +: 4] = {4{instr[29+n]}};
    end

    always_comb begin
        probe  = 1'b0;
        stage1 = 1'b0;
        if (instr[34]) begin
            dst    = {instr[7], instr[6:3]};
            stage1 = combine(op, flags_in[rb], flags_in[ra]);
            result = (op2 == OP_KEEP) ? stage1 : combine(op2, flags_in[rc], stage1);
        end else begin
            dst    = {1'b0, instr[6:3]};
            probe  = instr[33] ? word[instr[16:13]] : ((word & mask) == instr[28:13]);
            result = combine(op, flags_in[dst], probe);
        end
        flags_out = flags_in;
        if (dst != 5'd0) flags_out[dst] = result;
    end
endmodule

// File: rtl/pkt_classifier.sv
module pkt_classifier
    import pcls_pkg::*;
#(
    parameter int PROG_DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr_en,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic [15:0] rx_data,
    output logic        result_valid,
    output logic [7:0]  result_class,
    output logic        result_drop
);
    localparam int AW = $clog2(PROG_DEPTH);
    localparam logic [AW-1:0] LAST = AW'(PROG_DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0]      pc;
        logic [NFLAGS-1:0]  flags;
        logic               halted;
        logic               reported;
        logic               res_valid;
        logic [CLASS_W-1:0] res_class;
        logic               res_drop;
    } state_t;

    state_t st_d, st_q;

    logic [AW-1:0]      idx;
    logic [NFLAGS-1:0]  flags_base, flags_exec, flags_after;
    logic [INSTR_W-1:0] instr;
    logic [OFF_W-1:0]   word_off;
    logic [WORD_W-1:0]  sel_word;
    logic               enable, ex_fin;
    logic               blocked, done, run, fin_hit, emit;

    assign idx        = rx_sof ? '0 : st_q.pc;
    assign flags_base = rx_sof ? '0 : st_q.flags;

    pcls_cfg #(.DEPTH(PROG_DEPTH)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr_en(cfg_wr_en),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .rd_addr  (idx),
        .instr    (instr),
        .enable   (enable)
    );

    pcls_wordbuf #(.DEPTH(PROG_DEPTH)) u_buf (
        .clk    (clk),
        .wr_en  (rx_valid),
        .wr_idx (idx),
        .wr_data(rx_data),
        .rd_off (word_off),
        .rd_word(sel_word)
    );

    pcls_exec u_exec (
        .instr    (instr),
        .word     (sel_word),
        .flags_in (flags_base),
        .word_off (word_off),
        .is_fin   (ex_fin),
        .flags_out(flags_exec)
    );

    always_comb begin
        st_d           = st_q;
        st_d.res_valid = 1'b0;
        blocked        = st_q.halted && !rx_sof;
        done           = st_q.reported && !rx_sof;
        run            = rx_valid && enable && !blocked;
        fin_hit        = run && ex_fin;
        flags_after    = (run && !ex_fin) ? flags_exec : flags_base;
        emit           = rx_valid && !done && (fin_hit || rx_eof);
        if (rx_valid) begin
            st_d.pc       = (idx == LAST) ? idx : idx + AW'(1);
            st_d.flags    = flags_after;
            st_d.halted   = blocked || fin_hit || (run && idx == LAST) || emit;
            st_d.reported = done || emit;
            if (emit) begin
                st_d.res_valid = 1'b1;
                st_d.res_class = enable ? flags_after[CLASS_BASE +: CLASS_W] : '0;
                st_d.res_drop  = enable && flags_after[DROP_FLAG];
                st_d.flags     = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_valid = st_q.res_valid;
    assign result_class = st_q.res_class;
    assign result_drop  = st_q.res_drop;
endmodule

// File: rtl/pcls_checker.sv
module pcls_checker #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          rx_sof,
    input logic          enable,
    input logic [AW-1:0] pc,
    input logic [31:0]   flags,
    input logic          result_valid,
    input logic [7:0]    result_class,
    input logic          result_drop
);
    AST_R0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        flags[0] == 1'b0); // R1

    AST_RESULT_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(rx_valid)); // R2

    AST_PC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_sof |=> pc == AW'(1)); // R3

    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> flags == 32'd0); // R10

    AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid && !$past(enable) |-> result_class == 8'd0 && !result_drop); // R12
endmodule

bind pkt_classifier pcls_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_sof      (rx_sof),
    .enable      (enable),
    .pc          (st_q.pc),
    .flags       (st_q.flags),
    .result_valid(result_valid),
    .result_class(result_class),
    .result_drop (result_drop)
);

// File: tb/tb_pkt_classifier.sv
`timescale 1ns/1ps
module tb_pkt_classifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic [15:0] rx_data = '0;
    logic        result_valid;
    logic [7:0]  result_class;
    logic        result_drop;

    int tests = 0, fails = 0;
    bit finished = 1'b0;
    int pulses, pulse_at;
    logic [7:0]  got_class;
    logic        got_drop;
    logic [15:0] fw [80];

    always #2.5 clk = ~clk;

    pkt_classifier dut (.*);

    // frame words w0..w4, expected class, expected drop
    localparam logic [88:0] VEC [5] = '{
        {16'hFFFF, 16'h1234, 16'h55A0, 16'h8000, 16'hBEEF, 8'h89, 1'b0},
        {16'hFFFE, 16'h1234, 16'h00A1, 16'h0001, 16'hBEEF, 8'h80, 1'b0},
        {16'hFFFF, 16'h0000, 16'h12A0, 16'h8001, 16'h0000, 8'h03, 1'b0},
        {16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'hBEEF, 8'h0A, 1'b1},
        {16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'h02, 1'b0}
    };

    function automatic logic [35:0] i_cmp(int off, logic [15:0] val, logic [3:0] nib, logic [2:0] op, int rd);
        return {3'b000, nib, val, 6'(off), 4'(rd), op};
    endfunction
    function automatic logic [35:0] i_bit(int off, int bitn, logic [2:0] op, int rd);
        return {3'b001, 16'h0, 4'(bitn), 6'(off), 4'(rd), op};
    endfunction
    function automatic logic [35:0] i_lg3(int rd, int ra, logic [2:0] op, int rb, logic [2:0] op2, int rc);
        logic [4:0] d = 5'(rd);
        return {2'b01, 8'h0, op2, 5'(rc), 5'(rb), 5'(ra), d[4], d[3:0], op};
    endfunction
    function automatic logic [35:0] i_lg2(int rd, int ra, logic [2:0] op, int rb);
        return i_lg3(rd, ra, op, rb, 3'd3, 0);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic sel, logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic load_word(int addr, logic [35:0] w);
        cfg_write(1'b1, {20'h0, w[11:0]});
        cfg_write(1'b0, {w[35:12], 6'(addr), 2'b10});
    endtask

    task automatic sample(int at);
        if (result_valid) begin
            pulses++;
            pulse_at  = at;
            got_class = result_class;
            got_drop  = result_drop;
        end
    endtask

    task automatic send_frame(int len);
        pulses = 0; pulse_at = -1; got_class = 'x; got_drop = 'x;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            sample(i);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1); rx_data = fw[i];
        end
        @(negedge clk);
        sample(len);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        @(negedge clk);
        sample(len + 1);
    endtask

    task automatic fill(logic [88:0] v, int len);
        for (int i = 0; i < 80; i++) fw[i] = 16'h0;
        if (len > 0) fw[0] = v[88:73];
        if (len > 1) fw[1] = v[72:57];
        if (len > 2) fw[2] = v[56:41];
        if (len > 3) fw[3] = v[40:25];
        if (len > 4) fw[4] = v[24:9];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R14 valid", 32'(result_valid), 0);
        check("R14 class", 32'(result_class), 0);
        check("R14 drop", 32'(result_drop), 0);
        rst_n = 1'b1;

        // program A
        load_word(0,  i_cmp(0, 16'hFFFF, 4'hF, 3'd4, 1));
        load_word(1,  i_cmp(1, 16'h1234, 4'hF, 3'd4, 2));
        load_word(2,  i_cmp(2, 16'h00A0, 4'b0011, 3'd4, 3));
        load_word(3,  i_bit(3, 15, 3'd4, 4));
        load_word(4,  i_bit(3, 0, 3'd2, 4));
        load_word(5,  i_lg3(24, 1, 3'd0, 2, 3'd1, 3));
        load_word(6,  i_lg2(25, 4, 3'd5, 0));
        load_word(7,  i_lg2(23, 1, 3'd2, 3));
        load_word(8,  i_lg2(31, 2, 3'd4, 0));
        load_word(9,  i_lg2(0, 2, 3'd1, 0));
        load_word(10, i_lg2(26, 0, 3'd1, 0));
        load_word(11, i_cmp(4, 16'hBEEF, 4'hF, 3'd0, 1));
        load_word(12, i_lg2(27, 1, 3'd4, 0));
        load_word(13, 36'h8_0000_0000);
        @(negedge clk);
        check("R14 disabled after load", 32'(result_valid), 0);
        cfg_write(1'b0, 32'h1);

        // table: R4 R5 R6 R7 R1 R2 R13, FIN at address 13 (R8)
        for (int k = 0; k < 5; k++) begin
            fill(VEC[k], 16);
            send_frame(16);
            check($sformatf("R4/R5/R6/R7/R13 class frame %0d", k), 32'(got_class), 32'(VEC[k][8:1]));
            check($sformatf("R2 drop frame %0d", k), 32'(got_drop), 32'(VEC[k][0]));
            check($sformatf("R8 single pulse frame %0d", k), pulses, 1);
        end
        check("R8 pulse from FIN word", pulse_at, 14);
        check("R1 flag 0 write ignored", 32'(got_class[2]), 0);

        // R9: frame ends before FIN, at word 6
        fill(VEC[3], 7);
        send_frame(7);
        check("R9 class at eof", 32'(got_class), 32'h02);
        check("R9 drop at eof", 32'(got_drop), 0);
        check("R9 pulse after last word", pulse_at, 7);

        // R10: drop-tagged frame then a one-word frame
        fill(VEC[3], 16);
        send_frame(16);
        fill(VEC[4], 1);
        send_frame(1);
        check("R10 class cleared", 32'(got_class), 0);
        check("R10 drop cleared", 32'(got_drop), 0);
        check("R10 pulse", pulses, 1);

        // R12: disabled, then re-enabled with program kept
        cfg_write(1'b0, 32'h0);
        fill(VEC[0], 16);
        send_frame(16);
        check("R12 disabled class", 32'(got_class), 0);
        check("R12 disabled drop", 32'(got_drop), 0);
        check("R12 disabled pulse", pulses, 1);
        cfg_write(1'b0, 32'h1);
        send_frame(16);
        check("R12 program kept", 32'(got_class), 32'h89);

        // R11: program B, address 0 clears class 0, address 63 sets it
        load_word(0, i_lg2(24, 0, 3'd4, 0));
        for (int a = 1; a < 63; a++) load_word(a, 36'h4_0000_0000);
        load_word(63, i_lg2(24, 0, 3'd5, 0));
        cfg_write(1'b0, 32'h1);
        for (int i = 0; i < 80; i++) fw[i] = 16'(i);
        send_frame(70);
        check("R11 long frame class", 32'(got_class), 32'h01);
        check("R11 long frame pulse at eof", pulse_at, 70);
        send_frame(63);
        check("R11 63-word frame class", 32'(got_class), 32'h00);
        check("R3 R9 63-word frame pulse", pulses, 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule